// File: doc/BRIEF.md
# T1 Remote Alarm Detector

This block watches a framed T1 receive stream for the remote alarm that the far end sends when it has lost the signal. It supports three alarm formats, chosen by two mode inputs.

In the first format, the second-most-significant bit of every channel byte is forced low for a long run. In the second, the S-bit of frame 12 is set. In the third, the facility data link carries a repeating `0x00FF` word. The receiver's framer feeds the block with a channel strobe and byte, a frame strobe with the frame number and S-bit, and a data-link bit strobe. Alignment is assumed to be already done upstream.

The single output is a level that reads high while the alarm is present. Each mode has its own rule for setting the alarm and its own rule for clearing it. Any change of mode discards all detection progress and drops the alarm.

Top module: `t1YellowDetect`

## Requirements
- R1: The mode is taken from {modeHi, modeLo}: `00` selects the channel-bit format, `01` selects the frame-12 S-bit format, and `10` or `11` selects the data-link format.
- R2: In channel-bit mode, a channel counts as marked when bit 6 of chanData (the second bit from the MSB) is 0. yellow rises in the cycle after the 256th consecutive marked channel is strobed. It stays low after 255 marked channels.
- R3: In channel-bit mode, a strobed channel with bit 6 equal to 1 drops yellow in the next cycle and restarts the run count from zero.
- R4: In S-bit mode, a frame strobe with frameNum equal to 12 and sBit equal to 1 raises yellow in the next cycle. Frame strobes with any other frameNum have no effect.
- R5: In S-bit mode, a frame strobe with frameNum equal to 12 and sBit equal to 0 drops yellow in the next cycle.
- R6: In data-link mode, each group of 16 consecutive strobed link bits forms one word, with the first bit as the MSB. Word boundaries count from reset or from entry into the mode.
- R7: In data-link mode, yellow rises in the cycle after the 16th consecutive word equal to `0x00FF` completes. It stays low after 15 such words.
- R8: In data-link mode, a completed word other than `0x00FF` drops yellow in the next cycle and restarts the word count.
- R9: A change of mode drops yellow in the next cycle and clears all run, word and bit progress. Inputs arriving in that cycle are discarded.
- R10: Strobes that belong to the formats of inactive modes have no effect on yellow.
- R11: After reset, yellow is low and the mode is channel-bit with no progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeHi | input | 1 | Upper mode select bit |
| modeLo | input | 1 | Lower mode select bit |
| chanValid | input | 1 | One-cycle strobe for a received channel byte |
| chanData | input | 8 | Channel byte, MSB first as transmitted |
| frameValid | input | 1 | One-cycle strobe once per frame |
| frameNum | input | 4 | Frame number within the multiframe, 1 to 12 |
| sBit | input | 1 | S-bit of the strobed frame |
| dlValid | input | 1 | Strobe for one data-link bit |
| dlBit | input | 1 | Data-link bit value |
| yellow | output | 1 | Remote alarm level |

## Verification
The assertions check, on every cycle, that the counters never pass their saturation points. They also check that a clearing event always drops yellow, and that yellow follows the frame-12 S-bit. Finally, they check that a mode change always leaves yellow low with empty counters.

Only the bench's scenarios can show the exact thresholds: 255 against 256 marked channels, and 15 against 16 good words. They are also the only way to show that the bit order of link words is correct, and that partial progress from before a mode change does not carry over.

// File: rtl/yellowPkg.sv
package yellowPkg;
  typedef enum logic [1:0] {
    MODE_BIT2 = 2'd0,
    MODE_SBIT = 2'd1,
    MODE_LINK = 2'd2
  } modeT;

  typedef struct packed {
    logic clr;       // mode changed: wipe all progress
    logic chanStb;   // channel byte to judge (channel-bit mode only)
    logic frameStb;  // selected frame S-bit to apply (S-bit mode only)
    logic linkStb;   // data-link bit to shift (data-link mode only)
  } stbT;
endpackage

// File: rtl/ytCtrl.sv
module ytCtrl
  import yellowPkg::*;
#(
  parameter int FRAME_W   = 4,
  parameter int FRAME_SEL = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeHi,
  input  logic               modeLo,
  input  logic               chanValid,
  input  logic               frameValid,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic               dlValid,
  output stbT                stb
);
  modeT modeNow, modeQ;

  always_comb begin
    if (modeHi)      modeNow = MODE_LINK;
    else if (modeLo) modeNow = MODE_SBIT;
    else             modeNow = MODE_BIT2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= MODE_BIT2;
    else       modeQ <= modeNow;
  end

  always_comb begin
    stb.clr      = (modeNow != modeQ);
    stb.chanStb  = !stb.clr && (modeQ == MODE_BIT2) && chanValid;
    stb.frameStb = !stb.clr && (modeQ == MODE_SBIT) && frameValid &&
                   (frameNum == FRAME_W'(FRAME_SEL));
    stb.linkStb  = !stb.clr && (modeQ == MODE_LINK) && dlValid;
  end

  // R10: at most one format is ever live in a cycle
  assert_one_format_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.chanStb, stb.frameStb, stb.linkStb}));
  // R9: the cycle after a mode change sees a settled mode
  assert_clr_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr && $stable(modeHi) && $stable(modeLo) |=> !stb.clr);
endmodule

// File: rtl/ytPath.sv
module ytPath
  import yellowPkg::*;
#(
  parameter int          CHAN_W    = 8,
  parameter int          RUN_LEN   = 256,
  parameter int          WORD_W    = 16,
  parameter int          LINK_REPS = 16,
  parameter logic [15:0] PATTERN   = 16'h00FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  stbT               stb,
  input  logic [CHAN_W-1:0] chanData,
  input  logic              sBit,
  input  logic              dlBit,
  output logic              yellow
);
  localparam int MARK_BIT = CHAN_W - 2;
  localparam int RUN_W    = $clog2(RUN_LEN + 1);
  localparam int REP_W    = $clog2(LINK_REPS + 1);
  localparam int BIT_W    = $clog2(WORD_W);

  logic [RUN_W-1:0]  runCnt;
  logic [REP_W-1:0]  repCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [WORD_W-1:0] shiftQ;
  logic [WORD_W-1:0] wordNow;
  logic              wordDone, wordGood, chanMark;

  assign chanMark = !chanData[MARK_BIT];
  assign wordNow  = {shiftQ[WORD_W-2:0], dlBit};
  assign wordDone = stb.linkStb && (bitCnt == BIT_W'(WORD_W - 1));
  assign wordGood = (wordNow == PATTERN[WORD_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN || stb.clr) begin
      runCnt <= '0;
      repCnt <= '0;
      bitCnt <= '0;
      shiftQ <= '0;
      yellow <= 1'b0;
    end else begin
      if (stb.chanStb) begin
        if (chanMark) begin
          if (runCnt != RUN_W'(RUN_LEN)) runCnt <= runCnt + 1'b1;
          if (runCnt >= RUN_W'(RUN_LEN - 1)) yellow <= 1'b1;
        end else begin
          runCnt <= '0;
          yellow <= 1'b0;
        end
      end
      if (stb.frameStb) yellow <= sBit;
      if (stb.linkStb) begin
        shiftQ <= wordNow;
        bitCnt <= bitCnt + 1'b1;
      end
      if (wordDone) begin
        if (wordGood) begin
          if (repCnt != REP_W'(LINK_REPS)) repCnt <= repCnt + 1'b1;
          if (repCnt >= REP_W'(LINK_REPS - 1)) yellow <= 1'b1;
        end else begin
          repCnt <= '0;
          yellow <= 1'b0;
        end
      end
    end
  end

  assert_run_sat_R2: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= RUN_W'(RUN_LEN));
  assert_rep_sat_R7: assert property (@(posedge clk) disable iff (!rstN)
    repCnt <= REP_W'(LINK_REPS));
  assert_chan_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.chanStb && chanData[MARK_BIT] |=> !yellow && runCnt == '0);
  assert_sbit_follow_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameStb |=> yellow == $past(sBit));
  assert_sbit_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameStb && !sBit |=> !yellow);
  assert_link_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    wordDone && !wordGood |=> !yellow && repCnt == '0);
  assert_mode_wipe_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> !yellow && runCnt == '0 && repCnt == '0 && bitCnt == '0);
endmodule

// File: rtl/t1YellowDetect.sv
module t1YellowDetect
  import yellowPkg::*;
#(
  parameter int CHAN_W    = 8,
  parameter int FRAME_W   = 4,
  parameter int RUN_LEN   = 256,
  parameter int LINK_REPS = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeHi,
  input  logic               modeLo,
  input  logic               chanValid,
  input  logic [CHAN_W-1:0]  chanData,
  input  logic               frameValid,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic               sBit,
  input  logic               dlValid,
  input  logic               dlBit,
  output logic               yellow
);
  stbT stb;

  ytCtrl #(.FRAME_W(FRAME_W), .FRAME_SEL(12)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeHi(modeHi), .modeLo(modeLo),
    .chanValid(chanValid), .frameValid(frameValid), .frameNum(frameNum),
    .dlValid(dlValid), .stb(stb)
  );

  ytPath #(
    .CHAN_W(CHAN_W), .RUN_LEN(RUN_LEN), .WORD_W(16),
    .LINK_REPS(LINK_REPS), .PATTERN(16'h00FF)
  ) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .chanData(chanData),
    .sBit(sBit), .dlBit(dlBit), .yellow(yellow)
  );

  // R11: out of reset the alarm is quiet
  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rstN |=> !yellow);
endmodule

// File: tb/t1YellowDetect_bench.sv
module t1YellowDetect_bench;
  logic clk = 0, rstN = 0, modeHi = 0, modeLo = 0;
  logic chanValid = 0, frameValid = 0, sBit = 0, dlValid = 0, dlBit = 0;
  logic [7:0] chanData = 0;
  logic [3:0] frameNum = 0;
  logic yellow;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  t1YellowDetect u_t1YellowDetect (
    .clk(clk), .rstN(rstN), .modeHi(modeHi), .modeLo(modeLo),
    .chanValid(chanValid), .chanData(chanData), .frameValid(frameValid),
    .frameNum(frameNum), .sBit(sBit), .dlValid(dlValid), .dlBit(dlBit),
    .yellow(yellow)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (yellow !== exp) begin
      fails++;
      $display("FAIL %s yellow=%b expected=%b", req, yellow, exp);
    end
  endtask

  task automatic sendChan(input logic [7:0] b);
    chanData = b; chanValid = 1; @(negedge clk); chanValid = 0;
  endtask

  task automatic sendFrame(input int n, input logic s);
    frameNum = 4'(n); sBit = s; frameValid = 1; @(negedge clk); frameValid = 0;
  endtask

  task automatic sendWord(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      dlBit = w[i]; dlValid = 1; @(negedge clk);
    end
    dlValid = 0;
  endtask

  task automatic setMode(input logic hi, input logic lo);
    modeHi = hi; modeLo = lo; @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, "R11 reset");
    rstN = 1; @(negedge clk);
    check(1'b0, "R11 after reset");

    // R2: marked run sweep, other bits varied, bit 6 held 0
    for (int n = 1; n <= 260; n++) begin
      sendChan(8'((n * 37) & 8'hBF));
      check(n >= 256, "R2 run threshold");
    end
    sendChan(8'h40);
    check(1'b0, "R3 clear on bit6=1");
    // R3: run restarts
    for (int n = 1; n <= 255; n++) sendChan(8'h00);
    sendChan(8'h7F);
    for (int n = 1; n <= 255; n++) sendChan(8'hBF);
    check(1'b0, "R3 run restarted");
    sendChan(8'h00);
    check(1'b1, "R3 full run after restart");

    // R10: foreign strobes in channel-bit mode
    sendFrame(12, 1'b0);
    sendWord(16'h1234);
    check(1'b1, "R10 foreign strobes ignored in bit2 mode");

    // R9 + R1: switch to S-bit mode drops alarm
    setMode(1'b0, 1'b1);
    check(1'b0, "R9 mode change drops alarm");

    // R4: only frame 12 matters
    for (int f = 1; f <= 11; f++) begin
      sendFrame(f, 1'b1);
      check(1'b0, "R4 non-12 frame ignored");
    end
    sendFrame(12, 1'b1);
    check(1'b1, "R4 frame12 set");
    sendFrame(5, 1'b0);
    check(1'b1, "R4 non-12 frame cannot clear");
    for (int n = 0; n < 300; n++) sendChan(8'h00);
    sendWord(16'h0F0F);
    check(1'b1, "R10 foreign strobes ignored in sbit mode");
    sendFrame(12, 1'b0);
    check(1'b0, "R5 frame12 clear");

    // R1 + R6 + R7: data-link mode via 10
    setMode(1'b1, 1'b0);
    for (int n = 1; n <= 18; n++) begin
      sendWord(16'h00FF);
      check(n >= 16, "R7 word threshold");
    end
    sendWord(16'h00FE);
    check(1'b0, "R8 bad word clears");
    for (int n = 1; n <= 15; n++) sendWord(16'h00FF);
    sendWord(16'hFF00);
    check(1'b0, "R6 reversed order is not the pattern");
    for (int n = 1; n <= 15; n++) sendWord(16'h00FF);
    check(1'b0, "R8 count restarted");
    sendWord(16'h00FF);
    check(1'b1, "R7 reached after restart");
    for (int n = 0; n < 300; n++) sendChan(8'h00);
    sendFrame(12, 1'b0);
    check(1'b1, "R10 foreign strobes ignored in link mode");

    // R1: 11 is also data-link; R9 wipes word progress on 10->11? no change of mode
    setMode(1'b1, 1'b1);
    check(1'b1, "R1 11 equals link mode");
    // R6: misaligned bits shift boundaries
    setMode(1'b0, 1'b0);
    check(1'b0, "R9 leave link mode");
    setMode(1'b1, 1'b0);
    dlBit = 0; dlValid = 1; @(negedge clk); dlValid = 0;
    for (int n = 1; n <= 16; n++) sendWord(16'h00FF);
    check(1'b0, "R6 word alignment from mode entry");

    // R9: partial run discarded
    setMode(1'b0, 1'b0);
    for (int n = 0; n < 200; n++) sendChan(8'h00);
    setMode(1'b0, 1'b1);
    setMode(1'b0, 1'b0);
    for (int n = 0; n < 100; n++) sendChan(8'h00);
    check(1'b0, "R9 run progress wiped");
    for (int n = 0; n < 156; n++) sendChan(8'h00);
    check(1'b1, "R2 fresh run completes");

    // R9: strobe in the change cycle is discarded
    modeLo = 1; frameNum = 12; sBit = 1; frameValid = 1;
    @(negedge clk); frameValid = 0;
    check(1'b0, "R9 change-cycle strobe dropped");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule